// File: doc/BRIEF.md
# Virtual Address Translation Unit

This block turns a 32-bit virtual byte address into a physical memory address for one load or store of 1, 2 or 4 bytes. Each request chooses between two translation schemes. The first is a linear page table held in local registers and indexed directly by the page number. The second is a small, fully associative translation buffer that software fills. The block runs a fixed sequence of checks on every request. When all checks pass, it returns the physical address and marks the entry it used. When a check fails, it returns a numbered fault code and leaves the entry as it was.

Pages are 128 bytes, and physical memory holds 128 frames, so a physical address is 14 bits wide. An entry can carry an all-ones frame number, which means no frame has been allocated to the page yet. When such an entry is used, the block asks an external frame allocator for a frame and stalls until the allocator answers. Software fills entries through a load port and can read them back, including the used and modified flags, through a readback port.

The controller is a four-state machine:

- `S_IDLE` accepts a request and moves to `S_EVAL`.
- `S_EVAL` evaluates the request. It moves to `S_ALLOC` when the entry's frame is unallocated, and to `S_RESP` otherwise.
- `S_ALLOC` holds the allocator request. It moves to `S_RESP` on a grant or a deny.
- `S_RESP` presents the response. It moves back to `S_IDLE` once the response is taken.

Top module: `vat_unit`

## Requirements
- R1: Alignment is checked before every other check. A word access (`req_size` 2 or 3) with either of address bits [1:0] set, or a half-word access (`req_size` 1) with address bit 0 set, returns code 5. A byte access (`req_size` 0) is never misaligned.
- R2: In page-table mode (`req_tlb_mode` 0), the page number is address bits [31:7]. A page number equal to or above `pt_limit` returns code 5. An entry in range whose valid flag is clear returns code 2.
- R3: In buffer mode (`req_tlb_mode` 1), the 4 entries are searched together. An entry matches only when it is valid and its stored page number equals the requested one. No match returns code 2. When several entries match, the lowest index is used.
- R4: A write that reaches an entry flagged read-only returns code 3. A read of the same entry translates normally.
- R5: An entry whose frame field is 8'hFF raises `alloc_req` and holds it, with no response, until `alloc_grant` or `alloc_deny` arrives. A grant writes `alloc_frame` into the entry's frame field. A deny returns code 8 and leaves the frame field at 8'hFF.
- R6: A frame number from 128 to 254, whether stored in the entry or granted by the allocator, returns code 4.
- R7: A translation with no fault returns code 0 and `rsp_paddr` = frame × 128 + address bits [6:0]. It sets the entry's used flag, and sets the modified flag only for writes.
- R8: Any response with a nonzero code carries `rsp_paddr` 0 and leaves the entry's used and modified flags unchanged.
- R9: `req_ready` is high only while idle. The mode select and all request fields are captured at acceptance. A response stays valid and unchanged until `rsp_ready` is seen.
- R10: After reset, `req_ready` is 1, `rsp_valid` and `alloc_req` are 0, and every entry of both tables reads back invalid with cleared flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual byte address |
| req_size | input | 2 | Access size: 0 byte, 1 half-word, 2 or 3 word |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_tlb_mode | input | 1 | 1 selects the associative buffer, 0 the page table |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 14 | Physical address, 0 on a fault |
| rsp_exc | output | 4 | Fault code (0 none, 2 page, 3 read-only, 4 bus, 5 address, 8 out of frames) |
| alloc_req | output | 1 | Frame requested from the allocator |
| alloc_grant | input | 1 | Allocator supplies `alloc_frame` |
| alloc_deny | input | 1 | Allocator has no frame |
| alloc_frame | input | 8 | Granted frame number |
| pt_limit | input | 5 | Number of page-table entries in use |
| ld_en | input | 1 | Write one entry |
| ld_tlb | input | 1 | Target of the write: 1 buffer, 0 page table |
| ld_idx | input | 4 | Entry index |
| ld_valid | input | 1 | Valid flag to load |
| ld_ro | input | 1 | Read-only flag to load |
| ld_vpn | input | 25 | Page number to load (used by the buffer search) |
| ld_frame | input | 8 | Frame number to load (8'hFF means unallocated) |
| rb_tlb | input | 1 | Readback source: 1 buffer, 0 page table |
| rb_idx | input | 4 | Readback index |
| rb_valid | output | 1 | Valid flag of the selected entry |
| rb_ro | output | 1 | Read-only flag of the selected entry |
| rb_used | output | 1 | Used flag of the selected entry |
| rb_dirty | output | 1 | Modified flag of the selected entry |
| rb_vpn | output | 25 | Page number of the selected entry |
| rb_frame | output | 8 | Frame number of the selected entry |

## Verification
A table of twenty requests covers both modes, both directions and all three sizes. Each fault in the check order is hit both alone and together with a lower-ranked fault, which tells whether the priority chain runs in the right order. For example, a misaligned half-word to an invalid page must report the address fault, and a read of a read-only page must still translate. In buffer mode, the table includes a page number that is mapped only in the page table and a page number present in two buffer entries; these separate a mode mix-up and a wrong search priority from correct behaviour. Directed tests then cover the allocator path (stalled grant, deny, and a granted frame out of range), a response held back by the consumer, a mode select changed right after acceptance, and the used and modified flags read back after each kind of outcome.

// File: rtl/vat_pkg.sv
package vat_pkg;
    parameter int VAT_VA_W    = 32;
    parameter int VAT_PAGE_B  = 128;
    parameter int VAT_FRAMES  = 128;
    parameter int VAT_OFF_W   = $clog2(VAT_PAGE_B);
    parameter int VAT_VPN_W   = VAT_VA_W - VAT_OFF_W;
    parameter int VAT_PFN_W   = $clog2(VAT_FRAMES);
    parameter int VAT_FRAME_W = VAT_PFN_W + 1;
    parameter int VAT_PA_W    = VAT_PFN_W + VAT_OFF_W;

    typedef enum logic [3:0] {
        EXC_NONE    = 4'd0,
        EXC_SYSCALL = 4'd1,
        EXC_PAGE    = 4'd2,
        EXC_RDONLY  = 4'd3,
        EXC_BUS     = 4'd4,
        EXC_ADDR    = 4'd5,
        EXC_OVF     = 4'd6,
        EXC_ILLEGAL = 4'd7,
        EXC_MEMLIM  = 4'd8
    } vat_exc_t;

    typedef struct packed {
        logic                   valid;
        logic                   ro;
        logic                   used;
        logic                   dirty;
        logic [VAT_FRAME_W-1:0] frame;
        logic [VAT_VPN_W-1:0]   vpn;
    } vat_entry_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_EVAL  = 2'd1,
        S_ALLOC = 2'd2,
        S_RESP  = 2'd3
    } vat_state_t;
endpackage

// File: rtl/vat_entry_store.sv
module vat_entry_store
    import vat_pkg::*;
#(
    parameter int N      = 4,
    parameter bit SEARCH = 1'b1,
    localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sw_we,
    input  logic [IW-1:0]        sw_idx,
    input  vat_entry_t           sw_ent,
    input  logic                 hw_we,
    input  logic [IW-1:0]        hw_idx,
    input  vat_entry_t           hw_ent,
    input  logic [IW-1:0]        rb_idx,
    output vat_entry_t           rb_ent,
    input  logic [VAT_VPN_W-1:0] lk_vpn,
    output logic                 lk_hit,
    output logic [IW-1:0]        lk_idx,
    output vat_entry_t           lk_ent
);
    vat_entry_t mem [N];

    // Software load wins over a hardware flag update to the same slot.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else begin
            if (hw_we) mem[hw_idx] <= hw_ent;
            if (sw_we) mem[sw_idx] <= sw_ent;
        end
    end

    assign rb_ent = mem[rb_idx];

    generate
        if (SEARCH) begin : g_assoc
            logic [N-1:0] match;
            for (genvar g = 0; g < N; g++) begin : g_cmp
                assign match[g] = mem[g].valid && (mem[g].vpn == lk_vpn);
            end
            // Descending scan so the lowest matching index is kept.
            always_comb begin
                lk_hit = 1'b0;
                lk_idx = '0;
                for (int i = N - 1; i >= 0; i--) begin
                    if (match[i]) begin
                        lk_hit = 1'b1;
                        lk_idx = IW'(i);
                    end
                end
            end
        end else begin : g_linear
            assign lk_hit = (lk_vpn < VAT_VPN_W'(N));
            assign lk_idx = lk_vpn[IW-1:0];
        end
    endgenerate

    assign lk_ent = mem[lk_idx];
endmodule

// File: rtl/vat_rule_check.sv
module vat_rule_check
    import vat_pkg::*;
(
    input  logic       tlb_mode,
    input  logic [1:0] size,
    input  logic [1:0] va_low,
    input  logic       write,
    input  logic       pt_in_range,
    input  logic       tlb_hit,
    input  vat_entry_t ent,
    output vat_exc_t   exc,
    output logic       need_alloc
);
    logic misalign;
    logic unalloc;
    logic bad_frame;

    assign misalign  = (size[1] && (va_low != 2'b00)) || ((size == 2'b01) && va_low[0]);
    assign unalloc   = (ent.frame == '1);
    assign bad_frame = (ent.frame >= VAT_FRAME_W'(VAT_FRAMES));

    // Fixed order: alignment, bounds/validity, write protection, allocation, frame range.
    always_comb begin
        exc        = EXC_NONE;
        need_alloc = 1'b0;
        if (misalign) begin
            exc = EXC_ADDR;
        end else if (!tlb_mode && !pt_in_range) begin
            exc = EXC_ADDR;
        end else if (!tlb_mode && !ent.valid) begin
            exc = EXC_PAGE;
        end else if (tlb_mode && !tlb_hit) begin
            exc = EXC_PAGE;
        end else if (ent.ro && write) begin
            exc = EXC_RDONLY;
        end else if (unalloc) begin
            need_alloc = 1'b1;
        end else if (bad_frame) begin
            exc = EXC_BUS;
        end
    end
endmodule

// File: rtl/vat_ctrl.sv
module vat_ctrl
    import vat_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VAT_VA_W-1:0]    req_vaddr,
    input  logic [1:0]             req_size,
    input  logic                   req_write,
    input  logic                   req_tlb_mode,
    output logic [VAT_VA_W-1:0]    q_vaddr,
    output logic [1:0]             q_size,
    output logic                   q_write,
    output logic                   q_tlb,
    input  vat_exc_t               chk_exc,
    input  logic                   chk_need_alloc,
    input  vat_entry_t             sel_ent,
    input  logic [IDX_W-1:0]       sel_idx,
    output logic                   alloc_req,
    input  logic                   alloc_grant,
    input  logic                   alloc_deny,
    input  logic [VAT_FRAME_W-1:0] alloc_frame,
    output logic                   upd_pt_we,
    output logic                   upd_tlb_we,
    output logic [IDX_W-1:0]       upd_idx,
    output vat_entry_t             upd_ent,
    output logic                   rsp_valid,
    input  logic                   rsp_ready,
    output logic [VAT_PA_W-1:0]    rsp_paddr,
    output vat_exc_t               rsp_exc
);
    vat_state_t state_q, state_d;
    vat_exc_t   res_exc_q;
    logic [VAT_PA_W-1:0] res_pa_q;
    logic upd_we;
    logic grant_ok;

    assign grant_ok = (alloc_frame < VAT_FRAME_W'(VAT_FRAMES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = S_EVAL;
            S_EVAL:  state_d = chk_need_alloc ? S_ALLOC : S_RESP;
            S_ALLOC: if (alloc_grant || alloc_deny) state_d = S_RESP;
            S_RESP:  if (rsp_ready) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Request capture and result registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_vaddr   <= '0;
            q_size    <= '0;
            q_write   <= 1'b0;
            q_tlb     <= 1'b0;
            res_exc_q <= EXC_NONE;
            res_pa_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        q_vaddr <= req_vaddr;
                        q_size  <= req_size;
                        q_write <= req_write;
                        q_tlb   <= req_tlb_mode;
                    end
                end
                S_EVAL: begin
                    if (!chk_need_alloc) begin
                        res_exc_q <= chk_exc;
                        res_pa_q  <= (chk_exc == EXC_NONE)
                                   ? {sel_ent.frame[VAT_PFN_W-1:0], q_vaddr[VAT_OFF_W-1:0]}
                                   : '0;
                    end
                end
                S_ALLOC: begin
                    if (alloc_grant) begin
                        res_exc_q <= grant_ok ? EXC_NONE : EXC_BUS;
                        res_pa_q  <= grant_ok
                                   ? {alloc_frame[VAT_PFN_W-1:0], q_vaddr[VAT_OFF_W-1:0]}
                                   : '0;
                    end else if (alloc_deny) begin
                        res_exc_q <= EXC_MEMLIM;
                        res_pa_q  <= '0;
                    end
                end
                S_RESP: ;
                default: ;
            endcase
        end
    end

    // Handshake outputs and entry write-back.
    always_comb begin
        req_ready = (state_q == S_IDLE);
        rsp_valid = (state_q == S_RESP);
        alloc_req = (state_q == S_ALLOC);
        upd_we    = 1'b0;
        upd_ent   = sel_ent;
        unique case (state_q)
            S_EVAL: begin
                if (!chk_need_alloc && (chk_exc == EXC_NONE)) begin
                    upd_we        = 1'b1;
                    upd_ent.used  = 1'b1;
                    upd_ent.dirty = sel_ent.dirty | q_write;
                end
            end
            S_ALLOC: begin
                if (alloc_grant) begin
                    upd_we        = 1'b1;
                    upd_ent.frame = alloc_frame;
                    if (grant_ok) begin
                        upd_ent.used  = 1'b1;
                        upd_ent.dirty = sel_ent.dirty | q_write;
                    end
                end
            end
            default: ;
        endcase
    end

    assign upd_pt_we  = upd_we && !q_tlb;
    assign upd_tlb_we = upd_we && q_tlb;
    assign upd_idx    = sel_idx;
    assign rsp_paddr  = res_pa_q;
    assign rsp_exc    = res_exc_q;

    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_exc)));

    p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_valid && !alloc_req));

    p_alloc_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !alloc_grant && !alloc_deny) |=> (alloc_req && !rsp_valid));

    p_fault_zero_pa_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_exc != EXC_NONE)) |-> (rsp_paddr == '0));

    p_no_upd_on_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_EVAL) && (chk_exc != EXC_NONE)) |-> !(upd_pt_we || upd_tlb_we));
endmodule

// File: rtl/vat_unit.sv
module vat_unit
    import vat_pkg::*;
#(
    parameter int TLB_N   = 4,
    parameter int PT_N    = 16,
    localparam int MAX_N  = (PT_N > TLB_N) ? PT_N : TLB_N,
    localparam int IDX_W  = $clog2(MAX_N),
    localparam int LIM_W  = $clog2(PT_N) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VAT_VA_W-1:0]    req_vaddr,
    input  logic [1:0]             req_size,
    input  logic                   req_write,
    input  logic                   req_tlb_mode,
    output logic                   rsp_valid,
    input  logic                   rsp_ready,
    output logic [VAT_PA_W-1:0]    rsp_paddr,
    output logic [3:0]             rsp_exc,
    output logic                   alloc_req,
    input  logic                   alloc_grant,
    input  logic                   alloc_deny,
    input  logic [VAT_FRAME_W-1:0] alloc_frame,
    input  logic [LIM_W-1:0]       pt_limit,
    input  logic                   ld_en,
    input  logic                   ld_tlb,
    input  logic [IDX_W-1:0]       ld_idx,
    input  logic                   ld_valid,
    input  logic                   ld_ro,
    input  logic [VAT_VPN_W-1:0]   ld_vpn,
    input  logic [VAT_FRAME_W-1:0] ld_frame,
    input  logic                   rb_tlb,
    input  logic [IDX_W-1:0]       rb_idx,
    output logic                   rb_valid,
    output logic                   rb_ro,
    output logic                   rb_used,
    output logic                   rb_dirty,
    output logic [VAT_VPN_W-1:0]   rb_vpn,
    output logic [VAT_FRAME_W-1:0] rb_frame
);
    localparam int TLB_IW = (TLB_N > 1) ? $clog2(TLB_N) : 1;
    localparam int PT_IW  = (PT_N > 1) ? $clog2(PT_N) : 1;

    logic [VAT_VA_W-1:0] q_vaddr;
    logic [1:0]          q_size;
    logic                q_write, q_tlb;
    vat_entry_t          ld_ent, upd_ent, sel_ent;
    vat_entry_t          pt_rb, tlb_rb, pt_lk, tlb_lk;
    logic                pt_hit, tlb_hit, pt_in_range;
    logic [PT_IW-1:0]    pt_lk_idx;
    logic [TLB_IW-1:0]   tlb_lk_idx;
    logic [IDX_W-1:0]    sel_idx, upd_idx;
    logic                upd_pt_we, upd_tlb_we;
    vat_exc_t            chk_exc, rsp_exc_e;
    logic                chk_need_alloc;
    logic [VAT_VPN_W-1:0] q_vpn;

    assign ld_ent = '{valid: ld_valid, ro: ld_ro, used: 1'b0, dirty: 1'b0,
                      frame: ld_frame, vpn: ld_vpn};
    assign q_vpn  = q_vaddr[VAT_VA_W-1:VAT_OFF_W];

    vat_entry_store #(.N(PT_N), .SEARCH(1'b0)) u_pt (
        .clk(clk), .rst_n(rst_n),
        .sw_we(ld_en && !ld_tlb), .sw_idx(ld_idx[PT_IW-1:0]), .sw_ent(ld_ent),
        .hw_we(upd_pt_we), .hw_idx(upd_idx[PT_IW-1:0]), .hw_ent(upd_ent),
        .rb_idx(rb_idx[PT_IW-1:0]), .rb_ent(pt_rb),
        .lk_vpn(q_vpn), .lk_hit(pt_hit), .lk_idx(pt_lk_idx), .lk_ent(pt_lk)
    );

    vat_entry_store #(.N(TLB_N), .SEARCH(1'b1)) u_tlb (
        .clk(clk), .rst_n(rst_n),
        .sw_we(ld_en && ld_tlb), .sw_idx(ld_idx[TLB_IW-1:0]), .sw_ent(ld_ent),
        .hw_we(upd_tlb_we), .hw_idx(upd_idx[TLB_IW-1:0]), .hw_ent(upd_ent),
        .rb_idx(rb_idx[TLB_IW-1:0]), .rb_ent(tlb_rb),
        .lk_vpn(q_vpn), .lk_hit(tlb_hit), .lk_idx(tlb_lk_idx), .lk_ent(tlb_lk)
    );

    assign pt_in_range = pt_hit && (q_vpn < {{(VAT_VPN_W-LIM_W){1'b0}}, pt_limit});
    assign sel_ent     = q_tlb ? tlb_lk : pt_lk;
    assign sel_idx     = q_tlb ? IDX_W'(tlb_lk_idx) : IDX_W'(pt_lk_idx);

    vat_rule_check u_chk (
        .tlb_mode(q_tlb), .size(q_size), .va_low(q_vaddr[1:0]), .write(q_write),
        .pt_in_range(pt_in_range), .tlb_hit(tlb_hit), .ent(sel_ent),
        .exc(chk_exc), .need_alloc(chk_need_alloc)
    );

    vat_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_size(req_size), .req_write(req_write), .req_tlb_mode(req_tlb_mode),
        .q_vaddr(q_vaddr), .q_size(q_size), .q_write(q_write), .q_tlb(q_tlb),
        .chk_exc(chk_exc), .chk_need_alloc(chk_need_alloc),
        .sel_ent(sel_ent), .sel_idx(sel_idx),
        .alloc_req(alloc_req), .alloc_grant(alloc_grant), .alloc_deny(alloc_deny),
        .alloc_frame(alloc_frame),
        .upd_pt_we(upd_pt_we), .upd_tlb_we(upd_tlb_we), .upd_idx(upd_idx), .upd_ent(upd_ent),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_exc(rsp_exc_e)
    );

    assign rsp_exc = rsp_exc_e;

    vat_entry_t rb_ent;
    assign rb_ent   = rb_tlb ? tlb_rb : pt_rb;
    assign rb_valid = rb_ent.valid;
    assign rb_ro    = rb_ent.ro;
    assign rb_used  = rb_ent.used;
    assign rb_dirty = rb_ent.dirty;
    assign rb_vpn   = rb_ent.vpn;
    assign rb_frame = rb_ent.frame;

    p_word_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_exc == 4'd0) && q_size[1]) |-> (rsp_paddr[1:0] == 2'b00));

    p_code_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_exc inside {4'd0, 4'd2, 4'd3, 4'd4, 4'd5, 4'd8}));

    p_ro_write_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && q_write && (rsp_exc == 4'd0)) |-> !sel_ent.ro);
endmodule

// File: tb/sim_vat_unit.sv
`timescale 1ns/1ps
module sim_vat_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_tlb_mode = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_size = '0;
    logic        rsp_ready = 1'b1;
    logic        alloc_grant = 1'b0, alloc_deny = 1'b0;
    logic [7:0]  alloc_frame = '0;
    logic [4:0]  pt_limit = 5'd8;
    logic        ld_en = 1'b0, ld_tlb = 1'b0, ld_valid = 1'b0, ld_ro = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [24:0] ld_vpn = '0;
    logic [7:0]  ld_frame = '0;
    logic        rb_tlb = 1'b0;
    logic [3:0]  rb_idx = '0;
    logic        req_ready, rsp_valid, alloc_req;
    logic [13:0] rsp_paddr;
    logic [3:0]  rsp_exc;
    logic        rb_valid, rb_ro, rb_used, rb_dirty;
    logic [24:0] rb_vpn;
    logic [7:0]  rb_frame;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vat_unit u0 (.*);

    // {tlb, wr, size[1:0], vaddr[31:0], exc[3:0], paddr[13:0]}
    localparam int NV = 20;
    localparam logic [53:0] VECS [NV] = '{
        {1'b0, 1'b0, 2'd2, 32'h0000_0004, 4'd0, 14'd644},   // R7 read word
        {1'b0, 1'b1, 2'd0, 32'h0000_0033, 4'd0, 14'd691},   // R7 write byte
        {1'b0, 1'b0, 2'd2, 32'h0000_0082, 4'd5, 14'd0},     // R1 word misaligned
        {1'b0, 1'b0, 2'd1, 32'h0000_0101, 4'd5, 14'd0},     // R1 ahead of invalid page
        {1'b0, 1'b0, 2'd0, 32'h0000_0105, 4'd2, 14'd0},     // R2 invalid entry
        {1'b0, 1'b1, 2'd1, 32'h0000_00A2, 4'd3, 14'd0},     // R4 write read-only
        {1'b0, 1'b0, 2'd1, 32'h0000_00A2, 4'd0, 14'd1314},  // R4 read read-only
        {1'b0, 1'b0, 2'd0, 32'h0000_0190, 4'd4, 14'd0},     // R6 frame 200
        {1'b0, 1'b0, 2'd2, 32'h0000_027C, 4'd0, 14'd16380}, // R7 top frame
        {1'b0, 1'b0, 2'd0, 32'h0000_0400, 4'd5, 14'd0},     // R2 page == limit
        {1'b0, 1'b0, 2'd0, 32'h0000_0380, 4'd2, 14'd0},     // R2 in range never loaded
        {1'b1, 1'b0, 2'd0, 32'h0000_2010, 4'd0, 14'd2576},  // R3 double hit, lowest
        {1'b1, 1'b1, 2'd2, 32'h0000_20C8, 4'd3, 14'd0},     // R4 buffer read-only
        {1'b1, 1'b0, 2'd2, 32'h0000_20C8, 4'd0, 14'd2760},  // R3 hit entry 1
        {1'b1, 1'b0, 2'd0, 32'h0000_2100, 4'd2, 14'd0},     // R3 invalid buffer entry
        {1'b1, 1'b0, 2'd0, 32'h0000_0004, 4'd2, 14'd0},     // R3 page-table-only page
        {1'b1, 1'b1, 2'd1, 32'h0000_2003, 4'd5, 14'd0},     // R1 buffer misaligned
        {1'b0, 1'b1, 2'd2, 32'h8000_0000, 4'd5, 14'd0},     // R2 huge page number
        {1'b0, 1'b0, 2'd3, 32'h0000_0002, 4'd5, 14'd0},     // R1 size code 3 is word
        {1'b1, 1'b1, 2'd0, 32'h0000_2011, 4'd0, 14'd2577}   // R7 buffer write
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load(input logic tlb, input logic [3:0] idx, input logic v, input logic ro,
                        input logic [24:0] vpn, input logic [7:0] fr);
        @(negedge clk);
        ld_en = 1'b1; ld_tlb = tlb; ld_idx = idx; ld_valid = v; ld_ro = ro;
        ld_vpn = vpn; ld_frame = fr;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic issue(input logic tlb, input logic wr, input logic [1:0] sz,
                         input logic [31:0] va, input bit flip,
                         output logic [3:0] exc, output logic [13:0] pa);
        @(negedge clk);
        req_valid = 1'b1; req_tlb_mode = tlb; req_write = wr; req_size = sz; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        if (flip) req_tlb_mode = ~tlb;
        while (!rsp_valid) @(negedge clk);
        exc = rsp_exc;
        pa  = rsp_paddr;
        @(negedge clk);
    endtask

    task automatic peek(input logic tlb, input logic [3:0] idx);
        rb_tlb = tlb; rb_idx = idx;
        #0.5;
    endtask

    task automatic start_alloc(input logic wr, input logic [31:0] va);
        @(negedge clk);
        req_valid = 1'b1; req_tlb_mode = 1'b0; req_write = wr; req_size = 2'd0; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 10 && !alloc_req; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [3:0]  e;
        logic [13:0] p;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 req_ready", req_ready, 1);
        chk("R10 rsp_valid", rsp_valid, 0);
        chk("R10 alloc_req", alloc_req, 0);
        peek(1'b0, 4'd0);
        chk("R10 pt valid", rb_valid, 0);
        peek(1'b1, 4'd3);
        chk("R10 tlb flags", {rb_valid, rb_used, rb_dirty}, 0);

        load(1'b0, 4'd0, 1, 0, 25'd0, 8'd5);
        load(1'b0, 4'd1, 1, 1, 25'd0, 8'd10);
        load(1'b0, 4'd2, 0, 0, 25'd0, 8'd3);
        load(1'b0, 4'd3, 1, 0, 25'd0, 8'd200);
        load(1'b0, 4'd4, 1, 0, 25'd0, 8'd127);
        load(1'b0, 4'd5, 1, 0, 25'd0, 8'hFF);
        load(1'b1, 4'd0, 1, 0, 25'h40, 8'd20);
        load(1'b1, 4'd1, 1, 1, 25'h41, 8'd21);
        load(1'b1, 4'd2, 1, 0, 25'h40, 8'd30);
        load(1'b1, 4'd3, 0, 0, 25'h42, 8'd40);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i][53], VECS[i][52], VECS[i][51:50], VECS[i][49:18], 1'b0, e, p);
            chk($sformatf("vector %0d code", i), e, VECS[i][17:14]);
            chk($sformatf("vector %0d paddr", i), p, VECS[i][13:0]);
        end

        // R7 and R8: flags after the table
        peek(1'b0, 4'd0); chk("R7 pt0 used+dirty", {rb_used, rb_dirty}, 2'b11);
        peek(1'b0, 4'd4); chk("R7 pt4 read only used", {rb_used, rb_dirty}, 2'b10);
        peek(1'b0, 4'd1); chk("R8 pt1 no dirty after ro fault", {rb_used, rb_dirty}, 2'b10);
        peek(1'b0, 4'd3); chk("R8 pt3 untouched on bus fault", {rb_used, rb_dirty}, 2'b00);
        peek(1'b1, 4'd0); chk("R7 tlb0 used+dirty", {rb_used, rb_dirty}, 2'b11);
        peek(1'b1, 4'd2); chk("R3 tlb2 shadowed stays unused", rb_used, 0);
        peek(1'b1, 4'd1); chk("R8 tlb1 no dirty", {rb_used, rb_dirty}, 2'b10);

        // R5 grant after a stall
        start_alloc(1'b1, 32'h0000_0285);
        chk("R5 alloc_req raised", alloc_req, 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R5 stall no response", rsp_valid, 0);
            chk("R5 alloc_req held", alloc_req, 1);
        end
        alloc_grant = 1'b1; alloc_frame = 8'd9;
        @(negedge clk);
        alloc_grant = 1'b0;
        while (!rsp_valid) @(negedge clk);
        chk("R5 grant code", rsp_exc, 0);
        chk("R5 grant paddr", rsp_paddr, 14'd1157);
        @(negedge clk);
        peek(1'b0, 4'd5);
        chk("R5 frame written", rb_frame, 8'd9);
        chk("R7 alloc flags", {rb_used, rb_dirty}, 2'b11);

        // R5 deny
        load(1'b0, 4'd6, 1, 0, 25'd0, 8'hFF);
        start_alloc(1'b0, 32'h0000_0300);
        @(negedge clk);
        alloc_deny = 1'b1;
        @(negedge clk);
        alloc_deny = 1'b0;
        while (!rsp_valid) @(negedge clk);
        chk("R5 deny code", rsp_exc, 8);
        chk("R8 deny paddr", rsp_paddr, 0);
        @(negedge clk);
        peek(1'b0, 4'd6);
        chk("R5 deny frame kept", rb_frame, 8'hFF);
        chk("R8 deny flags", {rb_used, rb_dirty}, 2'b00);

        // R6 out-of-range grant
        start_alloc(1'b0, 32'h0000_0300);
        alloc_grant = 1'b1; alloc_frame = 8'd130;
        @(negedge clk);
        alloc_grant = 1'b0;
        while (!rsp_valid) @(negedge clk);
        chk("R6 granted frame 130 code", rsp_exc, 4);
        @(negedge clk);
        peek(1'b0, 4'd6);
        chk("R6 frame stored", rb_frame, 8'd130);
        chk("R8 bus fault flags", rb_used, 0);

        // R9 response held while consumer stalls
        rsp_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_tlb_mode = 1'b0; req_write = 1'b0; req_size = 2'd0;
        req_vaddr = 32'h0000_0011;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9 held valid", rsp_valid, 1);
            chk("R9 held paddr", rsp_paddr, 14'd657);
            chk("R9 busy not ready", req_ready, 0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        chk("R9 released", {rsp_valid, req_ready}, 2'b01);

        // R9 mode captured at acceptance
        issue(1'b1, 1'b0, 2'd0, 32'h0000_2010, 1'b1, e, p);
        chk("R9 mode sampled code", e, 0);
        chk("R9 mode sampled paddr", p, 14'd2576);

        finish_run();
    end
endmodule